// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps a processor's sense of time. It holds two independent 64-bit up-counting time bases (a main one and an alternate one), a 32-bit down-counting decrementer, an optional 32-bit hypervisor decrementer and a 64-bit utilisation counter. Every counter moves only in cycles where the shared tick strobe is high and the run enable is high. Dropping the run enable freezes all counters, and raising it again resumes them from the held values.

Software reaches the counters through a flat select field. Each 32-bit half of a time base is written on its own, and the other half is kept. A compatibility clock view exposes a masked copy of the main lower word. The decrementers raise sticky exception requests in two cases: when they count past zero, and when software writes a negative value over a non-negative one. A re-initialisation strobe loads both decrementers with all ones and clears the utilisation counter without raising an exception.

Top module: `tbdec_unit`

## Requirements
- R1: The main and alternate time bases, the utilisation counter and the decrementers each change by exactly one per cycle in which both `tick_en` and `run_en` are high, with the time bases and the utilisation counter counting up and the decrementers counting down. They do not change in any other cycle unless they are written or re-initialised.
- R2: Writing select 0 replaces the main lower word and keeps the upper word, and writing select 1 replaces the upper word and keeps the lower word. A write takes priority over a tick in the same cycle for the counter written.
- R3: A tick carries from the lower 32 bits into the upper 32 bits of a time base.
- R4: The alternate time base is written through selects 2 (lower) and 3 (upper) under the same rule as R2, and it is fully independent of the main one.
- R5: While `run_en` is low, all counters hold their values. After `run_en` returns high, they continue from the held values.
- R6: A decrementer that ticks at 0x00000000 becomes 0xFFFFFFFF and raises its exception request.
- R7: A decrementer write (select 4) raises the request when the written bit 31 is 1 and the current bit 31 is 0. A write of any other combination raises nothing.
- R8: An exception request stays high until its acknowledge strobe. A raise in the same cycle as an acknowledge wins.
- R9: The hypervisor decrementer (select 5) follows R6 to R8 with its own request and acknowledge. With `HDEC_EN`=0, it reads 0 and never raises a request.
- R10: The clock view (select 6) reads the main lower word ANDed with 0x3FFFFF80. A write to it stores the data ANDed with that mask into the main lower word and keeps the upper word.
- R11: `reinit` loads both decrementers with 0xFFFFFFFF and clears the utilisation counter. It raises no exception request, leaves the time bases untouched, and takes priority over writes.
- R12: After reset, both time bases and the utilisation counter are 0, both decrementers are 0xFFFFFFFF, and both requests are low.
- R13: The utilisation counter is read only, at selects 7 (lower) and 8 (upper). Writes to selects 7 to 15 change nothing, and reads of selects 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe shared by all counters |
| run_en | input | 1 | High to count, low to freeze |
| reinit | input | 1 | Reload decrementers, clear utilisation counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 32 | Read data for `rd_sel` |
| dec_ack | input | 1 | Clears the decrementer request |
| hdec_ack | input | 1 | Clears the hypervisor decrementer request |
| dec_irq | output | 1 | Decrementer exception request |
| hdec_irq | output | 1 | Hypervisor decrementer exception request |

## Verification
The counters are driven with tick bursts in three settings: free running, frozen and resumed. Comparing the frozen and resumed results separates a true hold from a lost count or a jump. Half-word writes are followed by bursts that cross a 32-bit boundary, which shows whether the carry comes from the kept upper word or from the new data. Decrementer writes cover positive over negative, negative over negative and negative over positive, so the R7 request is seen to fire in one case only. An expiry run with an acknowledge separates the sticky request from the single-cycle raise.

// File: rtl/tbdec_pkg.sv
`timescale 1ns/1ps
package tbdec_pkg;
    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_TB_LO   = 4'd0,
        SEL_TB_HI   = 4'd1,
        SEL_ATB_LO  = 4'd2,
        SEL_ATB_HI  = 4'd3,
        SEL_DEC     = 4'd4,
        SEL_HDEC    = 4'd5,
        SEL_CLKVIEW = 4'd6,
        SEL_UTIL_LO = 4'd7,
        SEL_UTIL_HI = 4'd8
    } reg_sel_e;

    localparam logic [31:0] CLKVIEW_MASK = 32'h3FFF_FF80;
endpackage

// File: rtl/tbdec_halfcnt.sv
`timescale 1ns/1ps
// Up counter whose two halves are written separately.
module tbdec_halfcnt #(
    parameter int unsigned W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           clr,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W/2-1:0] wdata,
    output logic [W-1:0]   value
);
    localparam int unsigned H = W / 2;

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (wr_lo) begin
            st_d.cnt = {st_q.cnt[W-1:H], wdata};
        end else if (wr_hi) begin
            st_d.cnt = {wdata, st_q.cnt[H-1:0]};
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;
endmodule

// File: rtl/tbdec_decr.sv
`timescale 1ns/1ps
// Down counter with sticky exception request.
module tbdec_decr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         reload,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack,
    output logic [W-1:0] value,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
    } state_t;

    state_t st_d, st_q;
    logic   raise;

    always_comb begin
        st_d  = st_q;
        raise = 1'b0;
        if (reload) begin
            st_d.cnt = '1;
        end else if (wr) begin
            st_d.cnt = wdata;
            raise    = wdata[W-1] && !st_q.cnt[W-1];
        end else if (adv) begin
            st_d.cnt = st_q.cnt - 1'b1;
            raise    = (st_q.cnt == '0);
        end
        if (raise)    st_d.irq = 1'b1;
        else if (ack) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;
    assign irq   = st_q.irq;
endmodule

// File: rtl/tbdec_unit.sv
`timescale 1ns/1ps
module tbdec_unit
    import tbdec_pkg::*;
#(
    parameter int unsigned TB_W    = 64,
    parameter bit          HDEC_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                run_en,
    input  logic                reinit,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [TB_W/2-1:0]   wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [TB_W/2-1:0]   rd_data,
    input  logic                dec_ack,
    input  logic                hdec_ack,
    output logic                dec_irq,
    output logic                hdec_irq
);
    localparam int unsigned HW = TB_W / 2;

    logic            adv;
    logic [TB_W-1:0] tb_val, atb_val, util_val;
    logic [HW-1:0]   dec_val, hdec_val;
    logic [HW-1:0]   tb_wdata;
    logic            tb_wr_lo, tb_wr_hi, atb_wr_lo, atb_wr_hi;
    logic            dec_wr, hdec_wr;

    assign adv = tick_en && run_en;

    always_comb begin
        tb_wr_lo  = wr_en && (wr_sel == SEL_TB_LO || wr_sel == SEL_CLKVIEW);
        tb_wr_hi  = wr_en && (wr_sel == SEL_TB_HI);
        atb_wr_lo = wr_en && (wr_sel == SEL_ATB_LO);
        atb_wr_hi = wr_en && (wr_sel == SEL_ATB_HI);
        dec_wr    = wr_en && (wr_sel == SEL_DEC);
        hdec_wr   = wr_en && (wr_sel == SEL_HDEC);
        tb_wdata  = (wr_sel == SEL_CLKVIEW) ? (wr_data & CLKVIEW_MASK[HW-1:0]) : wr_data;
    end

    tbdec_halfcnt #(.W(TB_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clr(1'b0),
        .wr_lo(tb_wr_lo), .wr_hi(tb_wr_hi), .wdata(tb_wdata), .value(tb_val)
    );

    tbdec_halfcnt #(.W(TB_W)) u_atb (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clr(1'b0),
        .wr_lo(atb_wr_lo), .wr_hi(atb_wr_hi), .wdata(wr_data), .value(atb_val)
    );

    tbdec_halfcnt #(.W(TB_W)) u_util (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clr(reinit),
        .wr_lo(1'b0), .wr_hi(1'b0), .wdata('0), .value(util_val)
    );

    tbdec_decr #(.W(HW)) u_dec (
        .clk(clk), .rst_n(rst_n), .adv(adv), .reload(reinit),
        .wr(dec_wr), .wdata(wr_data), .ack(dec_ack),
        .value(dec_val), .irq(dec_irq)
    );

    generate
        if (HDEC_EN) begin : g_hdec
            tbdec_decr #(.W(HW)) u_hdec (
                .clk(clk), .rst_n(rst_n), .adv(adv), .reload(reinit),
                .wr(hdec_wr), .wdata(wr_data), .ack(hdec_ack),
                .value(hdec_val), .irq(hdec_irq)
            );
        end else begin : g_no_hdec
            assign hdec_val = '0;
            assign hdec_irq = 1'b0;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_TB_LO:   rd_data = tb_val[HW-1:0];
            SEL_TB_HI:   rd_data = tb_val[TB_W-1:HW];
            SEL_ATB_LO:  rd_data = atb_val[HW-1:0];
            SEL_ATB_HI:  rd_data = atb_val[TB_W-1:HW];
            SEL_DEC:     rd_data = dec_val;
            SEL_HDEC:    rd_data = hdec_val;
            SEL_CLKVIEW: rd_data = tb_val[HW-1:0] & CLKVIEW_MASK[HW-1:0];
            SEL_UTIL_LO: rd_data = util_val[HW-1:0];
            SEL_UTIL_HI: rd_data = util_val[TB_W-1:HW];
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tbdec_unit_chk.sv
`timescale 1ns/1ps
module tbdec_unit_chk
    import tbdec_pkg::*;
#(
    parameter int unsigned TB_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                run_en,
    input logic                reinit,
    input logic                wr_en,
    input logic [SEL_W-1:0]    wr_sel,
    input logic [TB_W/2-1:0]   wr_data,
    input logic                dec_ack,
    input logic                dec_irq,
    input logic [TB_W-1:0]     tb_val,
    input logic [TB_W-1:0]     atb_val,
    input logic [TB_W-1:0]     util_val,
    input logic [TB_W/2-1:0]   dec_val
);
    localparam int unsigned HW = TB_W / 2;

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run_en && !wr_en) |=> (tb_val == $past(tb_val) + 1'b1)); // R1

    AST_HALF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_TB_LO) |=> (tb_val[TB_W-1:HW] == $past(tb_val[TB_W-1:HW]))); // R2

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> ($stable(tb_val) && $stable(atb_val))); // R5

    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run_en && !wr_en && !reinit && dec_val == '0) |=> (dec_val == '1 && dec_irq)); // R6

    AST_NEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DEC && !reinit && wr_data[HW-1] && !dec_val[HW-1]) |=> dec_irq); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_irq && !dec_ack) |=> dec_irq); // R8

    AST_CLKVIEW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLKVIEW) |=> ((tb_val[HW-1:0] & ~CLKVIEW_MASK[HW-1:0]) == '0)); // R10

    AST_REINIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (dec_val == '1 && util_val == '0)); // R11
endmodule

bind tbdec_unit tbdec_unit_chk #(.TB_W(TB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
    .reinit(reinit), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dec_ack(dec_ack), .dec_irq(dec_irq), .tb_val(tb_val),
    .atb_val(atb_val), .util_val(util_val), .dec_val(dec_val)
);

// File: tb/tbdec_unit_tb.sv
`timescale 1ns/1ps
module tbdec_unit_tb;
    import tbdec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, run_en = 1'b1, reinit = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_sel;
    logic [31:0] rd_data;
    logic        dec_ack = 1'b0, hdec_ack = 1'b0;
    logic        dec_irq, hdec_irq;

    always #2.5 clk = ~clk;

    tbdec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .reinit(reinit), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .dec_ack(dec_ack),
        .hdec_ack(hdec_ack), .dec_irq(dec_irq), .hdec_irq(hdec_irq)
    );

    // kind 0: rd_data at sel, 1: dec_irq, 2: hdec_irq
    typedef struct {
        int          kind;
        logic [3:0]  sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    bit    mon_busy = 1'b0;
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    initial begin
        rd_sel = '0;
        forever begin
            item_t it;
            logic [31:0] obs;
            while (q.size() == 0) #1;
            mon_busy = 1'b1;
            it = q.pop_front();
            rd_sel = it.sel;
            #1;
            case (it.kind)
                1:       obs = {31'd0, dec_irq};
                2:       obs = {31'd0, hdec_irq};
                default: obs = rd_data;
            endcase
            n_checks++;
            if (obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: sel %0d kind %0d actual %h expected %h",
                         it.tag, it.sel, it.kind, obs, it.exp);
            end
            mon_busy = 1'b0;
        end
    end

    task automatic expect_item(input int kind, input logic [3:0] sel,
                               input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        while (q.size() != 0 || mon_busy) #1;
    endtask

    task automatic expect_rd(input logic [3:0] sel, input logic [31:0] exp, input string tag);
        expect_item(0, sel, exp, tag);
    endtask

    task automatic ticks(input int n);
        @(negedge clk) tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk) tick_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic pulse_dec_ack();
        @(negedge clk) dec_ack = 1'b1;
        @(posedge clk);
        @(negedge clk) dec_ack = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R12 reset state
        expect_rd(SEL_TB_LO,   32'h0, "R12 tb lo");
        expect_rd(SEL_TB_HI,   32'h0, "R12 tb hi");
        expect_rd(SEL_ATB_LO,  32'h0, "R12 atb lo");
        expect_rd(SEL_DEC,     32'hFFFF_FFFF, "R12 dec");
        expect_rd(SEL_HDEC,    32'hFFFF_FFFF, "R12 hdec");
        expect_rd(SEL_UTIL_LO, 32'h0, "R12 util");
        expect_item(1, 0, 32'h0, "R12 dec_irq");
        expect_item(2, 0, 32'h0, "R12 hdec_irq");

        // R1 counting
        ticks(5);
        expect_rd(SEL_TB_LO,   32'd5, "R1 tb");
        expect_rd(SEL_ATB_LO,  32'd5, "R1 atb");
        expect_rd(SEL_UTIL_LO, 32'd5, "R1 util");
        expect_rd(SEL_DEC,     32'hFFFF_FFFA, "R1 dec");

        // R2 half writes, R3 carry
        wr(SEL_TB_HI, 32'h12);
        expect_rd(SEL_TB_LO, 32'd5,  "R2 lo kept");
        expect_rd(SEL_TB_HI, 32'h12, "R2 hi written");
        wr(SEL_TB_LO, 32'hFFFF_FFFE);
        expect_rd(SEL_TB_HI, 32'h12, "R2 hi kept");
        ticks(3);
        expect_rd(SEL_TB_LO, 32'h1,  "R3 lo wrap");
        expect_rd(SEL_TB_HI, 32'h13, "R3 carry");

        // R4 alternate base independent
        wr(SEL_ATB_LO, 32'h100);
        expect_rd(SEL_ATB_LO, 32'h100, "R4 atb lo");
        expect_rd(SEL_ATB_HI, 32'h0,   "R4 atb hi");
        expect_rd(SEL_TB_LO,  32'h1,   "R4 tb untouched");

        // R5 freeze and resume
        @(negedge clk) run_en = 1'b0;
        ticks(4);
        expect_rd(SEL_TB_LO,  32'h1,   "R5 frozen tb");
        expect_rd(SEL_ATB_LO, 32'h100, "R5 frozen atb");
        expect_rd(SEL_DEC,    32'hFFFF_FFF7, "R5 frozen dec");
        @(negedge clk) run_en = 1'b1;
        ticks(2);
        expect_rd(SEL_TB_LO,   32'h3,   "R5 resumed tb");
        expect_rd(SEL_ATB_LO,  32'h102, "R5 resumed atb");
        expect_rd(SEL_UTIL_LO, 32'd10,  "R5 resumed util");
        expect_rd(SEL_DEC,     32'hFFFF_FFF5, "R5 resumed dec");

        // R6 expiry, R8 sticky
        wr(SEL_DEC, 32'd2);
        expect_item(1, 0, 32'h0, "R7 positive write no irq");
        ticks(2);
        expect_rd(SEL_DEC, 32'h0, "R6 at zero");
        expect_item(1, 0, 32'h0, "R6 no irq at zero");
        ticks(1);
        expect_rd(SEL_DEC, 32'hFFFF_FFFF, "R6 wrap");
        expect_item(1, 0, 32'h1, "R6 irq");
        ticks(1);
        expect_item(1, 0, 32'h1, "R8 sticky");
        pulse_dec_ack();
        expect_item(1, 0, 32'h0, "R8 ack clears");

        // R7 negative write rules
        wr(SEL_DEC, 32'h8000_0000);
        expect_item(1, 0, 32'h0, "R7 neg over neg");
        wr(SEL_DEC, 32'h10);
        expect_item(1, 0, 32'h0, "R7 pos over neg");
        wr(SEL_DEC, 32'h8000_0005);
        expect_item(1, 0, 32'h1, "R7 neg over pos");
        expect_rd(SEL_DEC, 32'h8000_0005, "R7 value");
        pulse_dec_ack();

        // R9 hypervisor decrementer
        wr(SEL_HDEC, 32'd1);
        ticks(2);
        expect_rd(SEL_HDEC, 32'hFFFF_FFFF, "R9 hdec wrap");
        expect_item(2, 0, 32'h1, "R9 hdec irq");
        expect_item(1, 0, 32'h0, "R9 dec irq separate");
        @(negedge clk) hdec_ack = 1'b1;
        @(posedge clk);
        @(negedge clk) hdec_ack = 1'b0;
        expect_item(2, 0, 32'h0, "R9 hdec ack");

        // R10 clock view (tb lo is 9 here, hi 0x13)
        wr(SEL_CLKVIEW, 32'hFFFF_FFFF);
        expect_rd(SEL_TB_LO,   32'h3FFF_FF80, "R10 masked write");
        expect_rd(SEL_TB_HI,   32'h13,        "R10 hi kept");
        ticks(1);
        expect_rd(SEL_CLKVIEW, 32'h3FFF_FF80, "R10 masked read");
        expect_rd(SEL_TB_LO,   32'h3FFF_FF81, "R10 full lo");

        // R11 reinit
        @(negedge clk) reinit = 1'b1;
        @(posedge clk);
        @(negedge clk) reinit = 1'b0;
        expect_rd(SEL_DEC,     32'hFFFF_FFFF, "R11 dec");
        expect_rd(SEL_HDEC,    32'hFFFF_FFFF, "R11 hdec");
        expect_rd(SEL_UTIL_LO, 32'h0, "R11 util lo");
        expect_rd(SEL_UTIL_HI, 32'h0, "R11 util hi");
        expect_item(1, 0, 32'h0, "R11 no dec irq");
        expect_item(2, 0, 32'h0, "R11 no hdec irq");
        expect_rd(SEL_TB_LO,   32'h3FFF_FF81, "R11 tb untouched");

        // R13 read-only utilisation and unused selects
        wr(SEL_UTIL_LO, 32'h55);
        wr(4'd12, 32'h77);
        expect_rd(SEL_UTIL_LO, 32'h0, "R13 util unchanged");
        expect_rd(4'd12, 32'h0, "R13 unused reads zero");
        expect_rd(SEL_TB_LO, 32'h3FFF_FF81, "R13 tb unchanged");

        // R2 write beats tick in the same cycle
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_sel = SEL_DEC; wr_data = 32'h20;
        @(posedge clk);
        @(negedge clk) begin tick_en = 1'b0; wr_en = 1'b0; end
        expect_rd(SEL_DEC,   32'h20,        "R2 write priority");
        expect_rd(SEL_TB_LO, 32'h3FFF_FF82, "R1 tb ticked beside write");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule